// File: doc/BRIEF.md
# Dual-Mode FIFO with Programmable Flags

This block is an 18-bit synchronous first-in first-out buffer. A single clock runs both the write port and the read port, and the depth is a parameter. Two read-timing modes are chosen while master reset is held.

- **Standard mode.** A stored word reaches the registered output only after a read request.
- **Look-ahead mode.** The oldest word moves to the output by itself, and a read request consumes it.

The status pins change meaning with the mode. In standard mode they report empty and full. In look-ahead mode they report output-ready and input-ready.

Three occupancy flags come from a single occupancy count:

- a half-full flag;
- an almost-empty flag, with a programmable threshold;
- an almost-full flag, with a programmable threshold.

Master reset loads one of two preset threshold pairs. Software can later replace the thresholds, either bit by bit through a serial input or a whole value at a time through the data bus under a load strobe. Partial reset empties the buffer but keeps the thresholds and the mode. Retransmit rewinds the read side so that the stored words can be read again. An output enable gates the read data, standing in for a tri-state driver.

Top module: `dmf_fifo`

## Requirements
- R1: While `mreset` is high at a clock edge, the buffer empties. The mode is taken from `mode_sel` (0 = standard, 1 = look-ahead) and the thresholds from `offs_sel`. After release, all flags show the empty state.
- R2: A write (`wr_en` high, `ld_stb` low) is stored only when occupancy is below DEPTH. A write made while full is dropped, even in a cycle in which a read frees a place.
- R3: In standard mode, a read of a non-empty buffer places the oldest word on `rd_data` at that clock edge. A read of an empty buffer is ignored and `rd_data` holds, even when a write arrives in the same cycle.
- R4: In standard mode, `rd_stat` is 1 exactly when occupancy is 0, and `wr_stat` is 1 exactly when occupancy equals DEPTH.
- R5: In look-ahead mode, a word written to an empty buffer appears on `rd_data` after the second clock edge, without any read. `rd_stat` = 1 means a word is on the output and stays 1 until it is read. `wr_stat` = 1 means occupancy is below DEPTH.
- R6: `half_full` is 1 exactly when occupancy exceeds DEPTH/2.
- R7: `almost_empty` is 1 when occupancy is at most the low threshold. `almost_full` is 1 when free space (DEPTH minus occupancy) is at most the high threshold.
- R8: Master reset sets both thresholds to 127 when `offs_sel` = 0 and to 1023 when `offs_sel` = 1.
- R9: Each `ld_stb` cycle copies `wr_data[AW-1:0]` (AW = log2 DEPTH) into a threshold. The first strobe after master reset loads the low threshold, the next loads the high threshold, and they alternate from then on. No word is stored in a strobe cycle.
- R10: Each `ser_en` cycle shifts `ser_in` into the next threshold bit. The first AW bits fill the low threshold, least significant bit first, and the next AW bits fill the high threshold the same way.
- R11: `prst` empties the buffer and clears the output word, but keeps both thresholds and the mode.
- R12: `rexmit` moves the read side back to the first location. Occupancy becomes the number of words written since the last reset; this holds while that number is below DEPTH.
- R13: With `out_en` low, `rd_data` is all zeros and `rd_drive` is 0. With `out_en` high, `rd_data` shows the output word and `rd_drive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mreset | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| rexmit | input | 1 | Rewind read side to first location |
| mode_sel | input | 1 | Read mode, sampled during master reset |
| offs_sel | input | 1 | Preset threshold pair, sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word; threshold value under `ld_stb` |
| ld_stb | input | 1 | Parallel threshold load strobe |
| ser_en | input | 1 | Serial threshold shift strobe |
| ser_in | input | 1 | Serial threshold bit |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output enable |
| rd_data | output | 18 | Output word, zero when not enabled |
| rd_drive | output | 1 | Output is being driven |
| rd_stat | output | 1 | Empty (standard) or output-ready (look-ahead) |
| wr_stat | output | 1 | Full (standard) or input-ready (look-ahead) |
| half_full | output | 1 | More than half occupied |
| almost_empty | output | 1 | Occupancy at or below low threshold |
| almost_full | output | 1 | Free space at or below high threshold |

## Verification
A read and a write can land in the same cycle at either end of the occupancy range, and the outcome differs at each end.

- **Full buffer.** The bench fills all DEPTH places, then raises both requests together. The oldest word must come out, `wr_stat` must drop, and the colliding word must never appear in the read-back that follows.
- **Empty buffer.** A vector in the standard-mode table issues both requests at once. `rd_data` must keep its previous word while the empty flag clears, and the next read must return the word that was just written.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rdmode_e;

    typedef enum logic {
        OFS_LOW  = 1'b0,
        OFS_HIGH = 1'b1
    } ofs_tgt_e;

endpackage

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 18,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dmf_offsets.sv
module dmf_offsets
    import dmf_pkg::*;
#(
    parameter int OW     = 11,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023,
    localparam int SW    = $clog2(2 * OW)
) (
    input  logic          clk,
    input  logic          mreset,
    input  logic          sel_hi,
    input  logic          ld_stb,
    input  logic [OW-1:0] ld_data,
    input  logic          ser_en,
    input  logic          ser_in,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off
);

    localparam logic [OW-1:0] PRESET_LO = OW'(DEF_LO);
    localparam logic [OW-1:0] PRESET_HI = OW'(DEF_HI);
    localparam logic [SW-1:0] LAST_BIT  = SW'(2 * OW - 1);

    typedef struct packed {
        logic [OW-1:0] ae;
        logic [OW-1:0] af;
        logic [SW-1:0] bit_idx;
        ofs_tgt_e      ld_tgt;
    } ofs_st_t;

    ofs_st_t st_d, st_q, rst_st;

    always_comb begin
        rst_st         = '0;
        rst_st.ae      = sel_hi ? PRESET_HI : PRESET_LO;
        rst_st.af      = sel_hi ? PRESET_HI : PRESET_LO;
        rst_st.ld_tgt  = OFS_LOW;

        st_d = st_q;
        if (ld_stb) begin
            if (st_q.ld_tgt == OFS_LOW) begin
                st_d.ae     = ld_data;
                st_d.ld_tgt = OFS_HIGH;
            end else begin
                st_d.af     = ld_data;
                st_d.ld_tgt = OFS_LOW;
            end
        end else if (ser_en) begin
            for (int b = 0; b < OW; b++) begin
                if (st_q.bit_idx == SW'(b)) begin
                    st_d.ae[b] = ser_in;
                end
                if (st_q.bit_idx == SW'(b + OW)) begin
                    st_d.af[b] = ser_in;
                end
            end
            st_d.bit_idx = (st_q.bit_idx == LAST_BIT) ? '0 : st_q.bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (mreset) begin
            st_q <= rst_st;
        end else begin
            st_q <= st_d;
        end
    end

    assign ae_off = st_q.ae;
    assign af_off = st_q.af;

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic [CW-1:0] occ,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] free_cnt;

    always_comb begin
        free_cnt     = FULL_CNT - occ;
        half_full    = occ > HALF_CNT;
        almost_empty = occ <= {1'b0, ae_off};
        almost_full  = free_cnt <= {1'b0, af_off};
    end

endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
    import dmf_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int WIDTH  = 18,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             prst,
    input  logic             rexmit,
    input  logic             mode_sel,
    input  logic             offs_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ld_stb,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic             rd_en,
    input  logic             out_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive,
    output logic             rd_stat,
    output logic             wr_stat,
    output logic             half_full,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rdmode_e          mode;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        logic             ovld;
        logic [WIDTH-1:0] q;
    } fifo_st_t;

    fifo_st_t         st_d, st_q, rst_st;
    logic [WIDTH-1:0] mem_rd;
    logic [AW-1:0]    ae_off, af_off;
    logic [CW-1:0]    mem_cnt;
    logic [CW-1:0]    cnt_m;
    logic             fwft_m;
    logic             wr_acc, pop, fetch;

    dmf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (st_q.wptr),
        .wdata (wr_data),
        .raddr (st_q.rptr),
        .rdata (mem_rd)
    );

    dmf_offsets #(.OW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_offs (
        .clk     (clk),
        .mreset  (mreset),
        .sel_hi  (offs_sel),
        .ld_stb  (ld_stb),
        .ld_data (wr_data[AW-1:0]),
        .ser_en  (ser_en),
        .ser_in  (ser_in),
        .ae_off  (ae_off),
        .af_off  (af_off)
    );

    dmf_flags #(.DEPTH(DEPTH)) u_flags (
        .occ          (cnt_m),
        .ae_off       (ae_off),
        .af_off       (af_off),
        .half_full    (half_full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    assign cnt_m  = st_q.cnt;
    assign fwft_m = (st_q.mode == MODE_FWFT);

    always_comb begin
        rst_st      = '0;
        rst_st.mode = rdmode_e'(mode_sel);

        st_d    = st_q;
        wr_acc  = 1'b0;
        pop     = 1'b0;
        fetch   = 1'b0;
        mem_cnt = st_q.cnt - CW'(st_q.ovld);

        if (prst) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.ovld = 1'b0;
            st_d.q    = '0;
        end else if (rexmit) begin
            st_d.rptr = '0;
            st_d.cnt  = {1'b0, st_q.wptr};
            st_d.ovld = 1'b0;
        end else begin
            wr_acc = wr_en && !ld_stb && (st_q.cnt < FULL_CNT);
            if (fwft_m) begin
                pop   = rd_en && st_q.ovld;
                fetch = (mem_cnt != '0) && (!st_q.ovld || pop);
            end else begin
                pop   = rd_en && (st_q.cnt != '0);
                fetch = pop;
            end
            if (fetch) begin
                st_d.q    = mem_rd;
                st_d.rptr = st_q.rptr + 1'b1;
            end
            if (fwft_m) begin
                st_d.ovld = fetch || (st_q.ovld && !pop);
            end
            if (wr_acc) begin
                st_d.wptr = st_q.wptr + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(wr_acc) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (mreset) begin
            st_q <= rst_st;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stat  = fwft_m ? st_q.ovld : (st_q.cnt == '0);
    assign wr_stat  = fwft_m ? (st_q.cnt != FULL_CNT) : (st_q.cnt == FULL_CNT);
    assign rd_data  = out_en ? st_q.q : '0;
    assign rd_drive = out_en;

endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 18,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             mreset,
    input logic             prst,
    input logic             rexmit,
    input logic             wr_en,
    input logic             rd_en,
    input logic             out_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_stat,
    input logic             wr_stat,
    input logic             half_full,
    input logic             almost_empty,
    input logic             almost_full,
    input logic             fwft_m,
    input logic [CW-1:0]    cnt_m
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (mreset)
        cnt_m <= FULL_CNT);

    // R2
    full_write_drop_chk: assert property (@(posedge clk) disable iff (mreset)
        (!fwft_m && wr_stat && wr_en && !rd_en && !prst && !rexmit) |=> wr_stat);

    // R3
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (mreset)
        (!fwft_m && rd_stat && out_en && !prst) |=> (!out_en || rd_data == $past(rd_data)));

    // R5
    fwft_hold_chk: assert property (@(posedge clk) disable iff (mreset)
        (fwft_m && rd_stat && !rd_en && !prst && !rexmit) |=> rd_stat);

    // R6
    half_before_full_chk: assert property (@(posedge clk) disable iff (mreset)
        (!fwft_m && wr_stat) |-> half_full);

    // R11
    prst_clear_chk: assert property (@(posedge clk) disable iff (mreset)
        prst |=> (almost_empty && !half_full && !almost_full));

endmodule

bind dmf_fifo dmf_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .mreset       (mreset),
    .prst         (prst),
    .rexmit       (rexmit),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .out_en       (out_en),
    .rd_data      (rd_data),
    .rd_stat      (rd_stat),
    .wr_stat      (wr_stat),
    .half_full    (half_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .fwft_m       (fwft_m),
    .cnt_m        (cnt_m)
);

// File: tb/dmf_fifo_bench.sv
module dmf_fifo_bench;

    localparam int DEPTH = 2048;
    localparam int WIDTH = 18;
    localparam int AW    = $clog2(DEPTH);

    // {wr_en, rd_en, wr_data, expected rd_data, expected empty}
    localparam logic [38:0] VEC [10] = '{
        {1'b1, 1'b0, 18'h11111, 18'h00000, 1'b0},
        {1'b1, 1'b0, 18'h22222, 18'h00000, 1'b0},
        {1'b1, 1'b0, 18'h3ABCD, 18'h00000, 1'b0},
        {1'b0, 1'b1, 18'h00000, 18'h11111, 1'b0},
        {1'b0, 1'b1, 18'h00000, 18'h22222, 1'b0},
        {1'b1, 1'b1, 18'h04444, 18'h3ABCD, 1'b0},
        {1'b0, 1'b1, 18'h00000, 18'h04444, 1'b1},
        {1'b0, 1'b1, 18'h00000, 18'h04444, 1'b1},
        {1'b1, 1'b1, 18'h2FFFF, 18'h04444, 1'b0},
        {1'b0, 1'b1, 18'h00000, 18'h2FFFF, 1'b1}
    };

    logic             clk = 1'b0;
    logic             mreset = 1'b1;
    logic             prst = 1'b0;
    logic             rexmit = 1'b0;
    logic             mode_sel = 1'b0;
    logic             offs_sel = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             ld_stb = 1'b0;
    logic             ser_en = 1'b0;
    logic             ser_in = 1'b0;
    logic             rd_en = 1'b0;
    logic             out_en = 1'b1;
    logic [WIDTH-1:0] rd_data;
    logic             rd_drive, rd_stat, wr_stat, half_full, almost_empty, almost_full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dmf_fifo u_dmf_fifo (
        .clk (clk), .mreset (mreset), .prst (prst), .rexmit (rexmit),
        .mode_sel (mode_sel), .offs_sel (offs_sel),
        .wr_en (wr_en), .wr_data (wr_data), .ld_stb (ld_stb),
        .ser_en (ser_en), .ser_in (ser_in), .rd_en (rd_en), .out_en (out_en),
        .rd_data (rd_data), .rd_drive (rd_drive), .rd_stat (rd_stat),
        .wr_stat (wr_stat), .half_full (half_full),
        .almost_empty (almost_empty), .almost_full (almost_full)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // standard-mode flag expectations for occupancy n
    task automatic chk_flags(int n, int lo, int hi);
        chk("R4 empty", 32'(rd_stat), 32'(n == 0));
        chk("R4 full", 32'(wr_stat), 32'(n == DEPTH));
        chk("R6 half", 32'(half_full), 32'(n > DEPTH / 2));
        chk("R7 almost_empty", 32'(almost_empty), 32'(n <= lo));
        chk("R7 almost_full", 32'(almost_full), 32'((DEPTH - n) <= hi));
    endtask

    task automatic part_reset();
        prst = 1'b1;
        tick();
        prst = 1'b0;
    endtask

    task automatic fill_check(int lo, int hi);
        for (int i = 0; i < DEPTH; i++) begin
            wr_en   = 1'b1;
            wr_data = WIDTH'(i);
            tick();
            chk_flags(i + 1, lo, hi);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [38:0] v;
        repeat (3) tick();
        mreset = 1'b0;
        // R1 reset state (standard mode, preset 127)
        chk("R1 rd_stat", 32'(rd_stat), 32'd1);
        chk("R1 wr_stat", 32'(wr_stat), 32'd0);
        chk("R1 almost_empty", 32'(almost_empty), 32'd1);
        chk("R1 almost_full", 32'(almost_full), 32'd0);
        chk("R1 half", 32'(half_full), 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);

        // R3 R4 vector table
        for (int i = 0; i < 10; i++) begin
            v       = VEC[i];
            wr_en   = v[38];
            rd_en   = v[37];
            wr_data = v[36:19];
            tick();
            chk("R3 table data", 32'(rd_data), 32'(v[18:1]));
            chk("R4 table empty", 32'(rd_stat), 32'(v[0]));
        end
        wr_en = 1'b0;
        rd_en = 1'b0;

        // R2 R6 R7 R8 fill with presets, collision at full
        part_reset();
        chk_flags(0, 127, 127);
        fill_check(127, 127);
        wr_en   = 1'b1;
        wr_data = 18'h3FFFF;
        tick();
        chk("R2 full write dropped", 32'(wr_stat), 32'd1);
        rd_en = 1'b1;
        tick();
        chk("R2 read+write at full data", 32'(rd_data), 32'd0);
        chk("R2 read+write at full stat", 32'(wr_stat), 32'd0);
        wr_en = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            tick();
            chk("R2 R3 readback", 32'(rd_data), 32'(i));
        end
        rd_en = 1'b0;
        chk_flags(0, 127, 127);

        // R12 retransmit
        part_reset();
        for (int i = 0; i < 5; i++) begin
            wr_en   = 1'b1;
            wr_data = WIDTH'(32'h100 + i);
            tick();
        end
        wr_en = 1'b0;
        rd_en = 1'b1;
        tick();
        tick();
        chk("R12 pre-rewind", 32'(rd_data), 32'h101);
        rd_en  = 1'b0;
        rexmit = 1'b1;
        tick();
        rexmit = 1'b0;
        chk("R12 not empty", 32'(rd_stat), 32'd0);
        rd_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R12 reread", 32'(rd_data), 32'(32'h100 + i));
        end
        rd_en = 1'b0;
        chk("R12 drained", 32'(rd_stat), 32'd1);

        // R9 parallel load, R11 offsets survive partial reset
        part_reset();
        ld_stb  = 1'b1;
        wr_data = 18'd10;
        tick();
        wr_data = 18'd20;
        tick();
        ld_stb = 1'b0;
        chk("R9 no data stored", 32'(rd_stat), 32'd1);
        part_reset();
        fill_check(10, 20);

        // R10 serial load
        for (int b = 0; b < 2 * AW; b++) begin
            ser_en = 1'b1;
            ser_in = (b < AW) ? 1'((32'd5 >> b) & 1) : 1'((32'd300 >> (b - AW)) & 1);
            tick();
        end
        ser_en = 1'b0;
        part_reset();
        fill_check(5, 300);

        // R8 R1 upper preset
        mreset   = 1'b1;
        offs_sel = 1'b1;
        tick();
        mreset = 1'b0;
        fill_check(1023, 1023);

        // R5 look-ahead mode
        mreset   = 1'b1;
        mode_sel = 1'b1;
        offs_sel = 1'b0;
        tick();
        mreset = 1'b0;
        chk("R1 R5 ready low", 32'(rd_stat), 32'd0);
        chk("R1 R5 input ready", 32'(wr_stat), 32'd1);
        wr_en   = 1'b1;
        wr_data = 18'h1A5A5;
        tick();
        wr_en = 1'b0;
        chk("R5 not yet ready", 32'(rd_stat), 32'd0);
        tick();
        chk("R5 ready", 32'(rd_stat), 32'd1);
        chk("R5 fall-through data", 32'(rd_data), 32'h1A5A5);
        wr_en   = 1'b1;
        wr_data = 18'h00B0B;
        tick();
        wr_data = 18'h00C0C;
        tick();
        wr_en = 1'b0;
        chk("R5 held without read", 32'(rd_data), 32'h1A5A5);
        rd_en = 1'b1;
        tick();
        chk("R5 pop 1", 32'(rd_data), 32'h00B0B);
        tick();
        chk("R5 pop 2", 32'(rd_data), 32'h00C0C);
        tick();
        rd_en = 1'b0;
        chk("R5 drained", 32'(rd_stat), 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            wr_en   = 1'b1;
            wr_data = WIDTH'(i);
            tick();
            chk("R5 input ready", 32'(wr_stat), 32'(i + 1 < DEPTH));
        end
        wr_en = 1'b0;

        // R11 mode kept across partial reset
        mode_sel = 1'b0;
        part_reset();
        chk("R11 mode kept", 32'(rd_stat), 32'd0);
        wr_en   = 1'b1;
        wr_data = 18'h2D00D;
        tick();
        wr_en = 1'b0;
        tick();
        chk("R11 still look-ahead", 32'(rd_stat), 32'd1);
        chk("R11 data", 32'(rd_data), 32'h2D00D);

        // R13 output enable
        out_en = 1'b0;
        tick();
        chk("R13 gated data", 32'(rd_data), 32'd0);
        chk("R13 gated drive", 32'(rd_drive), 32'd0);
        out_en = 1'b1;
        tick();
        chk("R13 data", 32'(rd_data), 32'h2D00D);
        chk("R13 drive", 32'(rd_drive), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule